// File: doc/BRIEF.md
# Packed SIMD Saturating Adder/Subtractor

This block is a 32-bit packed arithmetic unit for a signal-processing pipeline stage. One opcode picks how the two operands are split into lanes (four unsigned bytes, two unsigned halfwords, two signed halfwords in Q15 form, or one signed Q31 word). It also picks whether the lanes are added or subtracted, and how each lane result is formed: plain wrap-around, clamping to the lane range, or halving of the full-precision value with or without rounding.

A second group of opcodes shares the same result register. In that group the block can:
- sum the four bytes of one operand,
- do a word add that records its carry-out,
- do a word add that consumes the recorded carry,
- step a circular-buffer index down by a byte count, reloading the index when it would go below zero.

Each accepted operation writes a registered result one cycle later. Any saturating lane, or a signed overflow in the carry-consuming add, sets a sticky overflow flag. The flag stays set until it is explicitly cleared.

Top module: `simd_addsub`

## Requirements
- R1: While rst_n is low, and after its release, result_o, ov_flag_o and carry_o are all 0.
- R2: An operation presented with valid_i high at a rising clock edge appears on result_o after that edge. When valid_i is low, result_o keeps its value.
- R3: The opcode op_i[5:0] has two groups. With op_i[5]=0 it is a lane operation:
  - op_i[4:3] selects the lanes: 00 is four unsigned bytes, 01 is two unsigned halfwords, 10 is two signed halfwords, 11 is one signed word. Lane i occupies bits starting at i times the lane width.
  - op_i[2]=1 subtracts rt_i from rs_i; op_i[2]=0 adds them.
  - op_i[1:0] selects the result form: 00 wrap, 01 saturate, 10 halve, 11 halve with rounding.
  - In wrap form each lane keeps the low lane-width bits of its sum or difference.
- R4: Unsigned saturating lanes clamp an add to all ones (0xFF or 0xFFFF) and a subtract to 0.
- R5: Signed saturating lanes clamp to the lane's largest positive value (0x7FFF or 0x7FFFFFFF) or its most negative value (0x8000 or 0x80000000).
- R6: In halving form a lane result is the full-precision sum or difference shifted right by one, arithmetic shift for signed lanes. With rounding, 1 is added before the shift. Halving never counts as saturation.
- R7: op_i = 6'b1xxx00 writes the zero-extended sum of the four bytes of rs_i; for example 0x80808080 gives 0x00000200.
- R8: op_i = 6'b1xxx01 writes rs_i + rt_i modulo 2^32 and loads carry_o with the unsigned carry-out.
- R9: op_i = 6'b1xxx10 writes rs_i + rt_i + carry_o modulo 2^32. It leaves carry_o unchanged, and it sets ov_flag_o when the signed 32-bit sum overflows.
- R10: op_i = 6'b1xxx11 treats rs_i as an unsigned index, rt_i[7:0] as a decrement and rt_i[31:8] as a reload value. It writes rs_i - rt_i[7:0] when rs_i >= rt_i[7:0]; a result of exactly 0 is kept. Otherwise it writes the zero-extended reload value.
- R11: ov_flag_o is set by any accepted operation that saturates a lane or overflows under R9. It is held until ov_clr_i is high at a clock edge; a new overflow in the same cycle as the clear leaves it set.
- R12: carry_o changes only on an accepted R8 operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation on this edge |
| op_i | input | 6 | Opcode (see R3, R7 to R10) |
| rs_i | input | 32 | First operand or circular-buffer index |
| rt_i | input | 32 | Second operand or decrement/reload pair |
| ov_clr_i | input | 1 | Clear the sticky overflow flag |
| result_o | output | 32 | Registered result |
| ov_flag_o | output | 1 | Sticky overflow flag |
| carry_o | output | 1 | Stored carry bit |

## Verification
The bench drives each lane boundary in both directions:
- an unsigned subtract that goes negative, which a design clamping at the wrong end would turn into 0xFF instead of 0;
- signed sums one step past the range, which a design that inspects the wrong bit would wrap;
- halving of odd sums, where a lost or misplaced rounding increment shows up in bit 0;
- a halving unsigned subtract with a negative difference, which a zero-extending shift would get wrong in the top bit.

The carry-producing add is followed by a carry-consuming add in the next cycle, and then by unrelated operations, which catches a carry that is not stored or that is overwritten. The modulo step is tried with the index below, equal to and above the decrement, since reloading on a zero result is the likely off-by-one. The sticky flag is tried with a clear on its own and with a clear in the same cycle as a new overflow.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    LN_UB = 2'b00,
    LN_UH = 2'b01,
    LN_SH = 2'b10,
    LN_SW = 2'b11
  } lane_kind_e;

  typedef enum logic [1:0] {
    MD_WRAP     = 2'b00,
    MD_SAT      = 2'b01,
    MD_HALF     = 2'b10,
    MD_HALF_RND = 2'b11
  } arith_mode_e;

  typedef enum logic [1:0] {
    SP_REDUCE   = 2'b00,
    SP_ADD_CGEN = 2'b01,
    SP_ADD_CUSE = 2'b10,
    SP_MODULO   = 2'b11
  } special_e;

  typedef struct packed {
    logic        special;
    lane_kind_e  kind;
    logic        sub;
    arith_mode_e mode;
  } op_t;

  localparam int OP_W = $bits(op_t);

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         signed_i,
  input  arith_mode_e  mode_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);

  localparam int FW = W + 2;

  function automatic logic [FW-1:0] widen(input logic [W-1:0] v, input logic sgn);
    return sgn ? {{2{v[W-1]}}, v} : {2'b00, v};
  endfunction

  function automatic logic [FW-1:0] full_calc(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic sgn, input logic sub);
    logic [FW-1:0] ea;
    logic [FW-1:0] eb;
    ea = widen(a, sgn);
    eb = widen(b, sgn);
    return sub ? (ea - eb) : (ea + eb);
  endfunction

  logic [FW-1:0] full;
  logic          lane_sat;

  assign full = full_calc(a_i, b_i, signed_i, sub_i);

  always_comb begin
    res_o    = full[W-1:0];
    lane_sat = 1'b0;
    unique case (mode_i)
      MD_WRAP: res_o = full[W-1:0];
      MD_SAT: begin
        if (signed_i) begin
          if (full[W] != full[W-1]) begin
            lane_sat = 1'b1;
            res_o    = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
          end
        end else if (full[W+1]) begin
          lane_sat = 1'b1;
          res_o    = '0;
        end else if (full[W]) begin
          lane_sat = 1'b1;
          res_o    = '1;
        end
      end
      MD_HALF:     res_o = full[W:1];
      MD_HALF_RND: res_o = W'((full + FW'(1)) >> 1);
      default:     res_o = full[W-1:0];
    endcase
  end

  assign sat_o = lane_sat;

  // R6
  always_comb begin
    if (sat_o) begin
      lane_sat_mode_chk: assert (mode_i == MD_SAT);
    end
  end

endmodule

// File: rtl/simd_special.sv
module simd_special
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEC_W  = 8
) (
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  special_e          sel_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              ovf_o
);

  localparam int NB = DATA_W / BYTE_W;

  function automatic logic [DATA_W-1:0] byte_sum(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NB; i++) begin
      acc = acc + DATA_W'(v[i*BYTE_W +: BYTE_W]);
    end
    return acc;
  endfunction

  logic [DATA_W:0]   cgen_sum;
  logic [DATA_W:0]   cuse_sum;
  logic [DATA_W-1:0] dec;
  logic [DATA_W-1:0] reload;
  logic              underflow;

  assign cgen_sum  = {1'b0, rs_i} + {1'b0, rt_i};
  assign cuse_sum  = {rs_i[DATA_W-1], rs_i} + {rt_i[DATA_W-1], rt_i} + {{DATA_W{1'b0}}, carry_i};
  assign dec       = {{(DATA_W-DEC_W){1'b0}}, rt_i[DEC_W-1:0]};
  assign reload    = {{DEC_W{1'b0}}, rt_i[DATA_W-1:DEC_W]};
  assign underflow = rs_i < dec;

  always_comb begin
    cout_o = 1'b0;
    ovf_o  = 1'b0;
    unique case (sel_i)
      SP_REDUCE:   res_o = byte_sum(rs_i);
      SP_ADD_CGEN: begin
        res_o  = cgen_sum[DATA_W-1:0];
        cout_o = cgen_sum[DATA_W];
      end
      SP_ADD_CUSE: begin
        res_o = cuse_sum[DATA_W-1:0];
        ovf_o = cuse_sum[DATA_W] != cuse_sum[DATA_W-1];
      end
      SP_MODULO:   res_o = underflow ? reload : (rs_i - dec);
      default:     res_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [5:0]        op_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic              ov_clr_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ov_flag_o,
  output logic              carry_o
);

  localparam int HALF_W = 2 * BYTE_W;
  localparam int NB     = DATA_W / BYTE_W;
  localparam int NH     = DATA_W / HALF_W;

  op_t op;
  assign op = op_t'(op_i);

  logic [DATA_W-1:0] byte_res;
  logic [NB-1:0]     byte_sat;
  logic [DATA_W-1:0] half_res;
  logic [NH-1:0]     half_sat;
  logic [DATA_W-1:0] word_res;
  logic              word_sat;
  logic              half_signed;

  assign half_signed = (op.kind == LN_SH);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    simd_lane #(.W(BYTE_W)) u_lane (
      .a_i      (rs_i[g*BYTE_W +: BYTE_W]),
      .b_i      (rt_i[g*BYTE_W +: BYTE_W]),
      .sub_i    (op.sub),
      .signed_i (1'b0),
      .mode_i   (op.mode),
      .res_o    (byte_res[g*BYTE_W +: BYTE_W]),
      .sat_o    (byte_sat[g])
    );
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    simd_lane #(.W(HALF_W)) u_lane (
      .a_i      (rs_i[g*HALF_W +: HALF_W]),
      .b_i      (rt_i[g*HALF_W +: HALF_W]),
      .sub_i    (op.sub),
      .signed_i (half_signed),
      .mode_i   (op.mode),
      .res_o    (half_res[g*HALF_W +: HALF_W]),
      .sat_o    (half_sat[g])
    );
  end

  simd_lane #(.W(DATA_W)) u_word (
    .a_i      (rs_i),
    .b_i      (rt_i),
    .sub_i    (op.sub),
    .signed_i (1'b1),
    .mode_i   (op.mode),
    .res_o    (word_res),
    .sat_o    (word_sat)
  );

  logic [DATA_W-1:0] sp_res;
  logic              sp_cout;
  logic              sp_ovf;
  special_e          sp_sel;

  assign sp_sel = special_e'(op.mode);

  simd_special #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEC_W(DEC_W)) u_special (
    .rs_i    (rs_i),
    .rt_i    (rt_i),
    .sel_i   (sp_sel),
    .carry_i (carry_o),
    .res_o   (sp_res),
    .cout_o  (sp_cout),
    .ovf_o   (sp_ovf)
  );

  logic [DATA_W-1:0] nxt_res;
  logic              sat_event;
  logic              carry_load;

  always_comb begin
    nxt_res    = sp_res;
    sat_event  = 1'b0;
    carry_load = 1'b0;
    if (op.special) begin
      sat_event  = (sp_sel == SP_ADD_CUSE) && sp_ovf;
      carry_load = (sp_sel == SP_ADD_CGEN);
    end else begin
      unique case (op.kind)
        LN_UB: begin
          nxt_res   = byte_res;
          sat_event = |byte_sat;
        end
        LN_UH, LN_SH: begin
          nxt_res   = half_res;
          sat_event = |half_sat;
        end
        default: begin
          nxt_res   = word_res;
          sat_event = word_sat;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      ov_flag_o <= 1'b0;
      carry_o   <= 1'b0;
    end else begin
      if (valid_i) begin
        result_o <= nxt_res;
      end
      if (valid_i && carry_load) begin
        carry_o <= sp_cout;
      end
      ov_flag_o <= (ov_flag_o && !ov_clr_i) || (valid_i && sat_event);
    end
  end

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o));

  // R11
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag_o && !ov_clr_i) |=> ov_flag_o);

  // R11
  ov_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sat_event) |=> ov_flag_o);

  // R12
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && op_i[5] && op_i[1:0] == 2'b01) |=> $stable(carry_o));

endmodule

// File: tb/test_simd_addsub.sv
module test_simd_addsub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  op_i = '0;
  logic [31:0] rs_i = '0;
  logic [31:0] rt_i = '0;
  logic        ov_clr_i = 1'b0;
  logic [31:0] result_o;
  logic        ov_flag_o;
  logic        carry_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_res = '0;
  logic        m_ov = 1'b0;
  logic        m_carry = 1'b0;

  always #2.5 clk = ~clk;

  simd_addsub i_simd_addsub (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .rs_i(rs_i), .rt_i(rt_i), .ov_clr_i(ov_clr_i),
    .result_o(result_o), .ov_flag_o(ov_flag_o), .carry_o(carry_o)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint lane_ref(input longint a, input longint b, input int w,
                                      input bit sgn, input bit sub, input int mode,
                                      output bit sat);
    longint mask, full, maxv, minv;
    mask = (longint'(1) << w) - 1;
    if (sgn && a[w-1]) a = a - (longint'(1) << w);
    if (sgn && b[w-1]) b = b - (longint'(1) << w);
    full = sub ? a - b : a + b;
    sat = 0;
    case (mode)
      0: return full & mask;
      1: begin
        if (sgn) begin
          maxv = (longint'(1) << (w - 1)) - 1;
          minv = -(longint'(1) << (w - 1));
        end else begin
          maxv = mask;
          minv = 0;
        end
        if (full > maxv) begin sat = 1; return maxv & mask; end
        if (full < minv) begin sat = 1; return minv & mask; end
        return full & mask;
      end
      2: return (full >>> 1) & mask;
      default: return ((full + 1) >>> 1) & mask;
    endcase
  endfunction

  task automatic model(input logic [5:0] op, input logic [31:0] rs, input logic [31:0] rt,
                       output logic [31:0] res, output bit ev, output bit cl, output bit cv);
    longint acc, s;
    bit sat;
    int w, n, kind;
    res = '0; ev = 0; cl = 0; cv = 0;
    if (!op[5]) begin
      kind = int'(op[4:3]);
      w = (kind == 0) ? 8 : (kind == 3) ? 32 : 16;
      n = 32 / w;
      acc = 0;
      for (int i = 0; i < n; i++) begin
        longint mask, a, b, r;
        mask = (longint'(1) << w) - 1;
        a = (longint'(rs) >> (i * w)) & mask;
        b = (longint'(rt) >> (i * w)) & mask;
        r = lane_ref(a, b, w, kind >= 2, op[2], int'(op[1:0]), sat);
        acc = acc | (r << (i * w));
        if (sat) ev = 1;
      end
      res = acc[31:0];
    end else begin
      case (op[1:0])
        2'b00: begin
          acc = 0;
          for (int i = 0; i < 4; i++) acc += (longint'(rs) >> (8 * i)) & 255;
          res = acc[31:0];
        end
        2'b01: begin
          s = longint'(rs) + longint'(rt);
          res = s[31:0]; cl = 1; cv = s[32];
        end
        2'b10: begin
          s = longint'($signed(rs)) + longint'($signed(rt)) + longint'(m_carry);
          res = s[31:0];
          ev = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        default: begin
          if (longint'(rs) < longint'(rt[7:0])) res = {8'h00, rt[31:8]};
          else res = rs - {24'h0, rt[7:0]};
        end
      endcase
    end
  endtask

  task automatic step(input string tag, input logic [5:0] op, input logic [31:0] rs,
                      input logic [31:0] rt, input bit vld, input bit clr);
    logic [31:0] r;
    bit ev, cl, cv;
    model(op, rs, rt, r, ev, cl, cv);
    op_i = op; rs_i = rs; rt_i = rt; valid_i = vld; ov_clr_i = clr;
    if (vld) m_res = r;
    if (vld && cl) m_carry = cv;
    m_ov = (m_ov && !clr) || (vld && ev);
    @(negedge clk);
    check(tag, "result", longint'(result_o), longint'(m_res));
    check(tag, "ov_flag", longint'(ov_flag_o), longint'(m_ov));
    check(tag, "carry", longint'(carry_o), longint'(m_carry));
  endtask

  function automatic string tag_of(input logic [5:0] op);
    if (op[5]) begin
      case (op[1:0])
        2'b00: return "R7";
        2'b01: return "R8";
        2'b10: return "R9";
        default: return "R10";
      endcase
    end
    case (op[1:0])
      2'b01: return (op[4:3] >= 2) ? "R5" : "R4";
      2'b10, 2'b11: return "R6";
      default: return "R3";
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "result", longint'(result_o), 0);
    check("R1", "ov_flag", longint'(ov_flag_o), 0);
    check("R1", "carry", longint'(carry_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "result after release", longint'(result_o), 0);

    // R3 wrap lanes
    step("R3", 6'b000000, 32'hFF01_8040, 32'h0202_8040, 1, 0);
    check("R3", "byte wrap value", longint'(result_o), 64'h0103_0080);
    step("R3", 6'b010100, 32'h0001_8000, 32'h0002_0001, 1, 0);
    step("R3", 6'b011000, 32'h7FFF_FFFF, 32'h0000_0001, 1, 0);
    // R2 hold
    step("R2", 6'b000000, 32'h1111_1111, 32'h2222_2222, 0, 0);
    step("R2", 6'b100000, 32'hFFFF_FFFF, 32'h0, 0, 0);
    // R4 unsigned saturation
    step("R4", 6'b000001, 32'hF0_10_80_01, 32'h20_10_80_01, 1, 0);
    check("R4", "byte sat add", longint'(result_o), 64'hFF_20_FF_02);
    step("R4", 6'b000101, 32'h10_00_05_80, 32'h20_01_05_7F, 1, 1);
    check("R4", "byte sat sub", longint'(result_o), 64'h00_00_00_01);
    step("R4", 6'b001001, 32'hFFF0_0001, 32'h0020_0001, 1, 1);
    step("R4", 6'b001101, 32'h0001_0005, 32'h0002_0003, 1, 1);
    // R5 signed saturation
    step("R5", 6'b010001, 32'h7FFF_8000, 32'h0001_FFFF, 1, 1);
    check("R5", "half sat add", longint'(result_o), 64'h7FFF_8000);
    step("R5", 6'b010101, 32'h8000_7FFF, 32'h0001_FFFF, 1, 1);
    step("R5", 6'b011001, 32'h7FFF_FFFF, 32'h0000_0001, 1, 1);
    check("R5", "word sat add", longint'(result_o), 64'h7FFF_FFFF);
    step("R5", 6'b011101, 32'h8000_0000, 32'h0000_0001, 1, 1);
    step("R5", 6'b011001, 32'h1234_0000, 32'h0000_5678, 1, 1);
    // R6 halving and rounding
    step("R6", 6'b000010, 32'h01_FF_03_00, 32'h00_FF_00_01, 1, 1);
    step("R6", 6'b000011, 32'h01_FF_03_00, 32'h00_FF_00_01, 1, 0);
    check("R6", "byte round", longint'(result_o), 64'h01_FF_02_01);
    step("R6", 6'b000110, 32'h00_00_00_00, 32'h01_02_03_04, 1, 0);
    step("R6", 6'b010011, 32'h7FFF_8000, 32'h7FFF_8001, 1, 0);
    step("R6", 6'b011110, 32'h8000_0000, 32'h7FFF_FFFF, 1, 0);
    step("R6", 6'b011111, 32'h0000_0003, 32'h0000_0000, 1, 0);
    // R7 reduction
    step("R7", 6'b100000, 32'h8080_8080, 32'hDEAD_BEEF, 1, 0);
    check("R7", "reduce value", longint'(result_o), 64'h200);
    step("R7", 6'b111100, 32'hFFFF_FFFF, 32'h0, 1, 0);
    // R8 / R12 carry chain
    step("R8", 6'b100001, 32'hFFFF_FFFF, 32'h0000_0001, 1, 0);
    check("R8", "carry set", longint'(carry_o), 1);
    step("R9", 6'b100010, 32'h0000_0000, 32'h0000_0000, 1, 0);
    check("R9", "carry consumed", longint'(result_o), 1);
    step("R12", 6'b000001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    step("R12", 6'b100011, 32'h0000_0010, 32'h0000_0001, 1, 1);
    check("R12", "carry held", longint'(carry_o), 1);
    step("R9", 6'b100010, 32'h7FFF_FFFF, 32'h0000_0000, 1, 0);
    check("R9", "overflow from carry add", longint'(ov_flag_o), 1);
    step("R8", 6'b100001, 32'h0000_0001, 32'h0000_0001, 1, 1);
    // R10 modulo
    step("R10", 6'b100011, 32'h0000_0010, 32'h0001_2310, 1, 0);
    check("R10", "equal gives zero", longint'(result_o), 0);
    step("R10", 6'b100011, 32'h0000_000F, 32'h0001_2310, 1, 0);
    check("R10", "underflow reload", longint'(result_o), 64'h123);
    step("R10", 6'b100011, 32'h0000_0020, 32'h0001_2310, 1, 0);
    // R11 sticky and clear
    step("R11", 6'b000001, 32'hFF, 32'h01, 1, 0);
    step("R11", 6'b000000, 32'h0, 32'h0, 1, 0);
    step("R11", 6'b000000, 32'h0, 32'h0, 0, 1);
    check("R11", "cleared", longint'(ov_flag_o), 0);
    step("R11", 6'b000001, 32'hFF, 32'h01, 1, 0);
    step("R11", 6'b000001, 32'hFF, 32'h01, 1, 1);
    check("R11", "set wins over clear", longint'(ov_flag_o), 1);

    for (int k = 0; k < 4000; k++) begin
      logic [5:0] op;
      logic [31:0] a, b;
      op = 6'($urandom);
      a = $urandom; b = $urandom;
      if ($urandom_range(0, 3) == 0) a = a | 32'h7F7F_7F7F;
      step(tag_of(op), op, a, b, $urandom_range(0, 4) != 0, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule